// File: doc/BRIEF.md
# Clock Source and Lock Status Sequencer

This block is the control logic that sits between a receiver's reference oscillator and the PLL that recovers a clock from incoming data. It does not touch the clocks themselves. It decides three things: when the oscillator may be stopped, when the recovered clock may be chosen as the working clock, and when the master clock for an external converter runs. It also drives a status line. That line marks the transitional phases after lock is gained and after lock is lost.

Once the PLL reports lock, the block waits for eight preamble-B frame starts before it gives up the oscillator. This holdoff gives the rate measurement time to finish. The block then holds the status line asserted until the receiver error flag clears. When lock is lost, the oscillator comes back at once and the status line stays asserted for 512 ticks of an oscillator-derived sample-rate strobe. Configuration bits can keep the oscillator running at all times, gate the master clock while locked, pick the master clock divider, invert the status polarity and stop all clock activity.

The lock, error and preamble inputs are asynchronous and each passes through a two-flop synchronizer. The sample-rate strobe is expected as a single-cycle pulse in the block clock domain.

Top module: `clk_src_seq`

## Requirements
- R1: After reset the block is in the unlocked phase: the oscillator input enable, oscillator run and master clock enable are 1, the recovered-clock select is 0, and the status output is deasserted (1 with polarity bit 0).
- R2: After lock is reported, the oscillator input enable and oscillator run stay 1 through seven preamble-B frame starts. Each frame start is a rising edge of the synchronized preamble input. On the eighth frame start both become 0 when keep-running is 0.
- R3: While the PLL is unlocked (including the settle phase), the oscillator input enable, oscillator run and master clock enable are 1 and the recovered-clock select is 0.
- R4: Once the eight-frame holdoff has elapsed with keep-running 0, the oscillator run, oscillator input enable and master clock enable are 0.
- R5: The master clock divide output is 1 (divide by 2) when the divide configuration bit is 1, and 0 (divide by 1) otherwise.
- R6: With keep-running 1, the oscillator input enable and run stay 1 in every phase. The gating bit drives the master clock enable to 0 only while the PLL is locked, and has no effect while unlocked.
- R7: During lock-in the status output is asserted from the moment lock is seen until the error flag is 0 after the holdoff. Once locked, a later error assertion does not reassert it.
- R8: After lock is lost, the status output stays asserted until the 512th sample-rate strobe and deasserts on that strobe.
- R9: With the polarity bit 1, the status output is 1 when asserted and 0 when deasserted.
- R10: With the stop bit 1, oscillator input enable, oscillator run, master clock enable and recovered-clock select are all 0 from the next cycle.
- R11: Losing lock during lock-in, or regaining it during the settle phase, restarts the counters of the new phase from zero. The status output stays asserted on every cycle across the switch.
- R12: The recovered-clock select is 1 only after the holdoff has elapsed while locked, and it is 0 in the cycle after the synchronized lock flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pll_lock_i | input | 1 | PLL lock flag, asynchronous |
| preamble_b_i | input | 1 | Preamble-B frame start pulse, asynchronous |
| rx_err_i | input | 1 | Receiver error flag, asynchronous |
| fs_tick_i | input | 1 | Oscillator-derived sample-rate strobe, one cycle wide |
| cfg_keep_run_i | input | 1 | Keep the oscillator active in every phase |
| cfg_mck_gate_i | input | 1 | Stop the master clock while locked (with keep-running) |
| cfg_mck_div2_i | input | 1 | Master clock divider: 0 = by 1, 1 = by 2 |
| cfg_stat_inv_i | input | 1 | Status polarity: 0 = asserted low, 1 = asserted high |
| cfg_stop_i | input | 1 | Halt all clock activity |
| osc_in_en_o | output | 1 | Oscillator input enable |
| osc_run_o | output | 1 | Oscillator amplifier run |
| mck_en_o | output | 1 | Master clock output enable |
| mck_div2_o | output | 1 | Master clock divide select |
| clk_sel_pll_o | output | 1 | 1 selects the recovered clock, 0 the oscillator |
| status_o | output | 1 | Lock-in/unlock status line |

## Verification
The hardest case to reach from the ports is a phase abort. Lock must drop partway through the preamble holdoff, or return partway through the 512-strobe settle, and the counter of the interrupted phase must not carry over. The stimulus drives 300 strobes, relocks, drops lock again and drives 300 more. A settle counter that was not cleared would end the phase early. It then gives five preambles, bounces the lock and gives seven more, which a holdoff counter that was not cleared would complete too soon. The status line is sampled on every cycle across these switches to catch a one-cycle release.

// File: rtl/clksq_pkg.sv
package clksq_pkg;

    typedef enum logic [2:0] {
        ST_UNLOCKED = 3'd0,
        ST_HOLD     = 3'd1,
        ST_WAIT_ERR = 3'd2,
        ST_LOCKED   = 3'd3,
        ST_SETTLE   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic osc_in_en;
        logic osc_run;
        logic mck_en;
        logic mck_div2;
        logic clk_sel_pll;
        logic status;
    } seq_out_t;

endpackage

// File: rtl/clksq_sync.sv
module clksq_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/clksq_fsm.sv
module clksq_fsm
    import clksq_pkg::*;
#(
    parameter int PREAMBLE_CNT = 8,
    parameter int SETTLE_TICKS = 512
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            lock_s,
    input  logic                            err_s,
    input  logic                            pre_s,
    input  logic                            fs_tick,
    output seq_state_e                      st_d,
    output seq_state_e                      st_q,
    output logic [$clog2(PREAMBLE_CNT)-1:0] pre_cnt_q,
    output logic [$clog2(SETTLE_TICKS)-1:0] set_cnt_q
);

    localparam int PRE_W = $clog2(PREAMBLE_CNT);
    localparam int SET_W = $clog2(SETTLE_TICKS);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PREAMBLE_CNT - 1);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_TICKS - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [PRE_W-1:0] pre;
        logic [SET_W-1:0] set;
        logic             pre_prev;
    } fsm_reg_t;

    fsm_reg_t r_d, r_q;
    logic     pre_rise;

    always_comb begin
        r_d          = r_q;
        r_d.pre_prev = pre_s;
        pre_rise     = pre_s & ~r_q.pre_prev;
        unique case (r_q.st)
            ST_UNLOCKED: begin
                if (lock_s) begin
                    r_d.st  = ST_HOLD;
                    r_d.pre = '0;
                end
            end
            ST_HOLD: begin
                if (!lock_s) begin
                    r_d.st  = ST_SETTLE;
                    r_d.set = '0;
                end else if (pre_rise) begin
                    if (r_q.pre == PRE_LAST) r_d.st = ST_WAIT_ERR;
                    else                     r_d.pre = r_q.pre + 1'b1;
                end
            end
            ST_WAIT_ERR: begin
                if (!lock_s) begin
                    r_d.st  = ST_SETTLE;
                    r_d.set = '0;
                end else if (!err_s) begin
                    r_d.st = ST_LOCKED;
                end
            end
            ST_LOCKED: begin
                if (!lock_s) begin
                    r_d.st  = ST_SETTLE;
                    r_d.set = '0;
                end
            end
            ST_SETTLE: begin
                if (lock_s) begin
                    r_d.st  = ST_HOLD;
                    r_d.pre = '0;
                end else if (fs_tick) begin
                    if (r_q.set == SET_LAST) r_d.st = ST_UNLOCKED;
                    else                     r_d.set = r_q.set + 1'b1;
                end
            end
            default: r_d.st = ST_UNLOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_UNLOCKED;
            r_q.pre      <= '0;
            r_q.set      <= '0;
            r_q.pre_prev <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign st_d      = r_d.st;
    assign st_q      = r_q.st;
    assign pre_cnt_q = r_q.pre;
    assign set_cnt_q = r_q.set;

endmodule

// File: rtl/clksq_outmap.sv
module clksq_outmap
    import clksq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e st_d,
    input  logic       keep_run,
    input  logic       mck_gate,
    input  logic       mck_div2,
    input  logic       stat_inv,
    input  logic       stop,
    output seq_out_t   out_q
);

    seq_out_t out_d;
    logic     holdoff_done;
    logic     pll_phase;
    logic     stat_active;
    logic     osc_on;

    always_comb begin
        holdoff_done = (st_d == ST_WAIT_ERR) || (st_d == ST_LOCKED);
        pll_phase    = holdoff_done || (st_d == ST_HOLD);
        stat_active  = (st_d == ST_HOLD) || (st_d == ST_WAIT_ERR) ||
                       (st_d == ST_SETTLE);
        osc_on       = keep_run | ~holdoff_done;

        out_d.osc_in_en   = osc_on & ~stop;
        out_d.osc_run     = osc_on & ~stop;
        out_d.mck_en      = ~stop & (keep_run ? ~(mck_gate & pll_phase)
                                              : ~holdoff_done);
        out_d.mck_div2    = mck_div2;
        out_d.clk_sel_pll = holdoff_done & ~stop;
        out_d.status      = stat_inv ? stat_active : ~stat_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.osc_in_en   <= 1'b1;
            out_q.osc_run     <= 1'b1;
            out_q.mck_en      <= 1'b1;
            out_q.mck_div2    <= 1'b0;
            out_q.clk_sel_pll <= 1'b0;
            out_q.status      <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

endmodule

// File: rtl/clk_src_seq.sv
module clk_src_seq
    import clksq_pkg::*;
#(
    parameter int PREAMBLE_CNT = 8,
    parameter int SETTLE_TICKS = 512,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_lock_i,
    input  logic preamble_b_i,
    input  logic rx_err_i,
    input  logic fs_tick_i,
    input  logic cfg_keep_run_i,
    input  logic cfg_mck_gate_i,
    input  logic cfg_mck_div2_i,
    input  logic cfg_stat_inv_i,
    input  logic cfg_stop_i,
    output logic osc_in_en_o,
    output logic osc_run_o,
    output logic mck_en_o,
    output logic mck_div2_o,
    output logic clk_sel_pll_o,
    output logic status_o
);

    localparam int PRE_W = $clog2(PREAMBLE_CNT);
    localparam int SET_W = $clog2(SETTLE_TICKS);

    logic [2:0]       async_vec;
    logic [2:0]       sync_vec;
    logic             lock_s, err_s, pre_s;
    seq_state_e       st_d, st_q;
    logic [PRE_W-1:0] pre_cnt_q;
    logic [SET_W-1:0] set_cnt_q;
    seq_out_t         out_q;

    assign async_vec = {pll_lock_i, rx_err_i, preamble_b_i};
    assign {lock_s, err_s, pre_s} = sync_vec;

    clksq_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (async_vec),
        .sync_o  (sync_vec)
    );

    clksq_fsm #(.PREAMBLE_CNT(PREAMBLE_CNT), .SETTLE_TICKS(SETTLE_TICKS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_s    (lock_s),
        .err_s     (err_s),
        .pre_s     (pre_s),
        .fs_tick   (fs_tick_i),
        .st_d      (st_d),
        .st_q      (st_q),
        .pre_cnt_q (pre_cnt_q),
        .set_cnt_q (set_cnt_q)
    );

    clksq_outmap u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_d     (st_d),
        .keep_run (cfg_keep_run_i),
        .mck_gate (cfg_mck_gate_i),
        .mck_div2 (cfg_mck_div2_i),
        .stat_inv (cfg_stat_inv_i),
        .stop     (cfg_stop_i),
        .out_q    (out_q)
    );

    assign osc_in_en_o   = out_q.osc_in_en;
    assign osc_run_o     = out_q.osc_run;
    assign mck_en_o      = out_q.mck_en;
    assign mck_div2_o    = out_q.mck_div2;
    assign clk_sel_pll_o = out_q.clk_sel_pll;
    assign status_o      = out_q.status;

endmodule

// File: rtl/clksq_chk.sv
module clksq_chk
    import clksq_pkg::*;
#(
    parameter int PRE_W    = 3,
    parameter int SET_W    = 9,
    parameter int PRE_LAST = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lock_s,
    input logic             fs_tick_i,
    input logic             cfg_keep_run_i,
    input logic             cfg_stop_i,
    input logic             osc_in_en_o,
    input logic             osc_run_o,
    input logic             mck_en_o,
    input logic             clk_sel_pll_o,
    input seq_state_e       st_q,
    input logic [PRE_W-1:0] pre_cnt_q,
    input logic [SET_W-1:0] set_cnt_q
);

    // R12
    sel_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_s |=> !clk_sel_pll_o);

    // R10
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_stop_i |=> (!osc_in_en_o && !osc_run_o && !mck_en_o && !clk_sel_pll_o));

    // R6
    keep_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_keep_run_i && !cfg_stop_i) |=> (osc_run_o && osc_in_en_o));

    // R2
    holdoff_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_ERR && $past(st_q) == ST_HOLD) |-> ($past(pre_cnt_q) == PRE_W'(PRE_LAST)));

    // R8
    settle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_UNLOCKED && $past(st_q) == ST_SETTLE) |-> ($past(fs_tick_i) && ($past(set_cnt_q) == '1)));

    // R11
    abort_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && $past(st_q) == ST_SETTLE) |-> (pre_cnt_q == '0));

endmodule

bind clk_src_seq clksq_chk #(
    .PRE_W    ($clog2(PREAMBLE_CNT)),
    .SET_W    ($clog2(SETTLE_TICKS)),
    .PRE_LAST (PREAMBLE_CNT - 1)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lock_s         (lock_s),
    .fs_tick_i      (fs_tick_i),
    .cfg_keep_run_i (cfg_keep_run_i),
    .cfg_stop_i     (cfg_stop_i),
    .osc_in_en_o    (osc_in_en_o),
    .osc_run_o      (osc_run_o),
    .mck_en_o       (mck_en_o),
    .clk_sel_pll_o  (clk_sel_pll_o),
    .st_q           (st_q),
    .pre_cnt_q      (pre_cnt_q),
    .set_cnt_q      (set_cnt_q)
);

// File: tb/clk_src_seq_test.sv
module clk_src_seq_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pll_lock_i = 1'b0, preamble_b_i = 1'b0, rx_err_i = 1'b0, fs_tick_i = 1'b0;
    logic cfg_keep_run_i = 1'b0, cfg_mck_gate_i = 1'b0, cfg_mck_div2_i = 1'b0;
    logic cfg_stat_inv_i = 1'b0, cfg_stop_i = 1'b0;
    logic osc_in_en_o, osc_run_o, mck_en_o, mck_div2_o, clk_sel_pll_o, status_o;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    logic watch_low = 1'b0;
    logic watch_bad = 1'b0;
    logic done = 1'b0;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    clk_src_seq uut (.*);

    // vector order: osc_in_en, osc_run, mck_en, mck_div2, clk_sel_pll, status
    wire [5:0] act_vec = {osc_in_en_o, osc_run_o, mck_en_o, mck_div2_o, clk_sel_pll_o, status_o};

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (watch_low && status_o !== 1'b0) watch_bad = 1'b1;
            while (exp_q.size() > 0) begin
                automatic logic [5:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                n_checks++;
                if (act_vec !== e) begin
                    n_fail++;
                    $display("FAIL %s: got %b expected %b", t, act_vec, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        wait (cycles > 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_vec(input string t, input logic [5:0] v);
        exp_q.push_back(v);
        tag_q.push_back(t);
        idle(2);
    endtask

    task automatic set_lock(input logic v);
        pll_lock_i = v;
        idle(4);
    endtask

    task automatic preambles(input int n);
        for (int i = 0; i < n; i++) begin
            preamble_b_i = 1'b1;
            idle(1);
            preamble_b_i = 1'b0;
            idle(3);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            fs_tick_i = 1'b1;
            idle(1);
            fs_tick_i = 1'b0;
            idle(1);
        end
        idle(1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        expect_vec("R1 reset state", 6'b111001);
        expect_vec("R3 unlocked outputs", 6'b111001);

        rx_err_i = 1'b1;
        set_lock(1'b1);
        expect_vec("R7 status asserted at lock", 6'b111000);
        preambles(7);
        expect_vec("R2 osc kept through 7 preambles", 6'b111000);
        preambles(1);
        expect_vec("R4 holdoff done, osc and mck off, R12 sel on", 6'b000010);
        rx_err_i = 1'b0;
        idle(4);
        expect_vec("R7 status released on error clear", 6'b000011);
        rx_err_i = 1'b1;
        idle(4);
        expect_vec("R7 error after lock ignored", 6'b000011);
        rx_err_i = 1'b0;

        set_lock(1'b0);
        expect_vec("R12 sel off when unlocked, R3 osc on", 6'b111000);
        ticks(511);
        expect_vec("R8 still settling at 511 ticks", 6'b111000);
        ticks(1);
        expect_vec("R8 settle done at 512 ticks", 6'b111001);

        // settle abort: 300 + relock + 300 must not finish
        rx_err_i = 1'b1;
        set_lock(1'b1);
        preambles(3);
        watch_low = 1'b1;
        set_lock(1'b0);
        ticks(300);
        set_lock(1'b1);
        set_lock(1'b0);
        ticks(300);
        watch_low = 1'b0;
        expect_vec("R11 settle counter restarted", 6'b111000);
        n_checks++;
        if (watch_bad) begin
            n_fail++;
            $display("FAIL R11 status glitch: got 1 expected 0");
        end
        ticks(212);
        expect_vec("R11 settle completes after restart", 6'b111001);

        // holdoff abort: 5 + bounce + 7 must not finish
        set_lock(1'b1);
        preambles(5);
        set_lock(1'b0);
        set_lock(1'b1);
        preambles(7);
        expect_vec("R11 holdoff counter restarted", 6'b111000);
        preambles(1);
        expect_vec("R2 holdoff after restart", 6'b000010);
        rx_err_i = 1'b0;
        idle(4);
        expect_vec("R7 locked", 6'b000011);

        cfg_stat_inv_i = 1'b1;
        idle(2);
        expect_vec("R9 inverted idle status", 6'b000010);
        cfg_stat_inv_i = 1'b0;
        cfg_mck_div2_i = 1'b1;
        idle(2);
        expect_vec("R5 divide by 2", 6'b000111);

        cfg_keep_run_i = 1'b1;
        idle(2);
        expect_vec("R6 keep-run locked", 6'b111111);
        cfg_mck_gate_i = 1'b1;
        idle(2);
        expect_vec("R6 gated mck while locked", 6'b110111);
        cfg_stop_i = 1'b1;
        idle(2);
        expect_vec("R10 stop forces clocks off", 6'b000101);
        cfg_stop_i = 1'b0;
        idle(2);
        expect_vec("R10 release stop", 6'b110111);
        set_lock(1'b0);
        expect_vec("R6 gate no effect when unlocked", 6'b111100);
        cfg_stat_inv_i = 1'b1;
        idle(2);
        expect_vec("R9 inverted asserted status", 6'b111101);

        idle(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule